// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter for a two-stage fetch/execute pipeline and produces the word address that goes to a 4K x 16-bit program memory each cycle. While one instruction executes, the word after it is being fetched, so straight-line code retires one instruction per clock. The unit is told by the decoder what the executing instruction does to control flow: plain fall-through, a PC-relative jump, a jump through the Z pointer, or an instruction that owns a second word. The decoder also supplies the signed offset, the Z value and a stall.

Addresses count 16-bit words. All arithmetic wraps modulo 4096. A taken jump makes the word already fetched from the old path useless, so the unit raises `flush` for the next cycle. That cycle is a bubble in the execute slot while the jump target is being fetched. A two-word instruction does not flush. Its second word is the word fetched during its own execute cycle, which the datapath takes as an operand, and the PC then steps over it.

Top module: `pcn_next_addr`

## Requirements
- R1: While `rstN` is low, `pc` and `fetchAddr` are 0 and `flush` is 1. The first cycle after reset is therefore a bubble while word 0 is fetched.
- R2: In a cycle with `flush` high and `stall` low, the next cycle keeps `pc` unchanged, sets `fetchAddr` to `pc`+1 and clears `flush`.
- R3: With `jumpKind` = 2'b00 (fall-through), `flush` low and `stall` low, the next cycle has `pc` = old `pc`+1, `fetchAddr` = old `pc`+2 and `flush` low, all modulo 4096.
- R4: With `jumpKind` = 2'b01 (relative), `flush` low and `stall` low, the next cycle has `pc` = `fetchAddr` = old `pc` + k + 1 modulo 4096, and `flush` high. Here k is `relOfs` read as 12-bit two's complement.
- R5: With `jumpKind` = 2'b10 (indirect), `flush` low and `stall` low, the next cycle has `pc` = `fetchAddr` = `zPtr[11:0]` and `flush` high. `zPtr[15:12]` has no effect.
- R6: With `jumpKind` = 2'b11 (two-word instruction), `flush` low and `stall` low, the next cycle has `pc` = old `pc`+2, `fetchAddr` = old `pc`+3 and `flush` low, all modulo 4096.
- R7: With `stall` high, `pc`, `fetchAddr` and `flush` keep their values, whatever the other inputs are.
- R8: In a cycle with `flush` high, `jumpKind`, `relOfs` and `zPtr` have no effect on the next state. The behaviour of R2 applies.
- R9: At every cycle out of reset, `fetchAddr` equals `pc` when `flush` is high and `pc`+1 (modulo 4096) when `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| jumpKind | input | 2 | Control-flow kind of the executing instruction: 00 fall-through, 01 relative, 10 indirect, 11 two-word |
| relOfs | input | 12 | Signed word offset k for a relative jump |
| zPtr | input | 16 | Z pointer value; only the low 12 bits are used |
| stall | input | 1 | Freeze the whole unit for this cycle |
| pc | output | 12 | Word address of the instruction in the execute slot |
| fetchAddr | output | 12 | Word address driven to program memory this cycle |
| flush | output | 1 | Execute slot holds a discarded word this cycle |

## Verification
The checker tests every cycle for the next-state rule of each jump kind, the hold under stall, the refill after a bubble, and the fixed offset between `fetchAddr` and `pc`. Whether the offset arithmetic is right for every possible k, and whether the Z upper bits are really ignored across the whole target range, can only be shown by the bench. It sweeps all 4096 offsets and all 4096 indirect targets, including the wrap at the top of memory and stalls placed inside a bubble.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

  typedef enum logic [1:0] {
    JK_SEQ = 2'b00,
    JK_REL = 2'b01,
    JK_IND = 2'b10,
    JK_DBL = 2'b11
  } jumpKind_e;

  typedef enum logic [2:0] {
    SEL_SEQ,
    SEL_REL,
    SEL_IND,
    SEL_DBL,
    SEL_REFILL
  } addrSel_e;

  typedef struct packed {
    logic     hold;
    addrSel_e sel;
    logic     taken;
  } pcStrobes_t;

endpackage

// File: rtl/pcn_ctrl.sv
module pcn_ctrl
  import pcn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] jumpKind,
  input  logic       stall,
  output pcStrobes_t strb,
  output logic       flush
);

  jumpKind_e kindIn;
  assign kindIn = jumpKind_e'(jumpKind);

  always_comb begin
    strb.hold  = stall;
    strb.taken = 1'b0;
    strb.sel   = SEL_SEQ;
    if (flush) begin
      strb.sel = SEL_REFILL;
    end else begin
      unique case (kindIn)
        JK_SEQ: strb.sel = SEL_SEQ;
        JK_DBL: strb.sel = SEL_DBL;
        JK_REL: begin
          strb.sel   = SEL_REL;
          strb.taken = 1'b1;
        end
        JK_IND: begin
          strb.sel   = SEL_IND;
          strb.taken = 1'b1;
        end
        default: strb.sel = SEL_SEQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flush <= 1'b1;
    end else if (!strb.hold) begin
      flush <= strb.taken;
    end
  end

endmodule

// File: rtl/pcn_datapath.sv
module pcn_datapath
  import pcn_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int OFS_W = 12,
  parameter int Z_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobes_t       strb,
  input  logic [OFS_W-1:0] relOfs,
  input  logic [Z_W-1:0]   zPtr,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  fetchAddr
);

  localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2);

  logic [PC_W-1:0] ofsExt;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] fetchNext;

  generate
    if (OFS_W < PC_W) begin : g_ofsWiden
      assign ofsExt = {{(PC_W-OFS_W){relOfs[OFS_W-1]}}, relOfs};
    end else begin : g_ofsTrim
      assign ofsExt = relOfs[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (strb.sel)
      SEL_SEQ:    target = pc + STEP1;
      SEL_DBL:    target = pc + STEP2;
      SEL_REL:    target = pc + ofsExt + STEP1;
      SEL_IND:    target = zPtr[PC_W-1:0];
      SEL_REFILL: target = pc;
      default:    target = pc;
    endcase
  end

  always_comb begin
    pcNext = target;
    if (strb.taken) begin
      fetchNext = target;
    end else begin
      fetchNext = target + STEP1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= '0;
      fetchAddr <= '0;
    end else if (!strb.hold) begin
      pc        <= pcNext;
      fetchAddr <= fetchNext;
    end
  end

endmodule

// File: rtl/pcn_next_addr.sv
module pcn_next_addr
  import pcn_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int OFS_W = 12,
  parameter int Z_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       jumpKind,
  input  logic [OFS_W-1:0] relOfs,
  input  logic [Z_W-1:0]   zPtr,
  input  logic             stall,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  fetchAddr,
  output logic             flush
);

  pcStrobes_t strb;

  pcn_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .jumpKind (jumpKind),
    .stall    (stall),
    .strb     (strb),
    .flush    (flush)
  );

  pcn_datapath #(
    .PC_W  (PC_W),
    .OFS_W (OFS_W),
    .Z_W   (Z_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .relOfs    (relOfs),
    .zPtr      (zPtr),
    .pc        (pc),
    .fetchAddr (fetchAddr)
  );

endmodule

// File: rtl/pcn_chk.sv
module pcn_chk #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 12,
  parameter int Z_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       jumpKind,
  input logic [OFS_W-1:0] relOfs,
  input logic [Z_W-1:0]   zPtr,
  input logic             stall,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  fetchAddr,
  input logic             flush
);

  logic            live;
  logic [PC_W-1:0] kWide;

  assign live  = !stall && !flush;
  assign kWide = PC_W'($signed(relOfs));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (live && jumpKind == 2'b00) |=> (pc == $past(pc) + PC_W'(1)) && !flush);

  assert_rel_jump_R4: assert property (@(posedge clk) disable iff (!rstN)
    (live && jumpKind == 2'b01) |=>
      (pc == $past(pc) + $past(kWide) + PC_W'(1)) && flush);

  assert_ind_jump_R5: assert property (@(posedge clk) disable iff (!rstN)
    (live && jumpKind == 2'b10) |=> (pc == $past(zPtr[PC_W-1:0])) && flush);

  assert_two_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (live && jumpKind == 2'b11) |=> (pc == $past(pc) + PC_W'(2)) && !flush);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(pc) && $stable(fetchAddr) && $stable(flush));

  assert_bubble_refill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !stall) |=> $stable(pc) && !flush);

  assert_fetch_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr == (flush ? pc : pc + PC_W'(1)));

endmodule

bind pcn_next_addr pcn_chk #(
  .PC_W  (PC_W),
  .OFS_W (OFS_W),
  .Z_W   (Z_W)
) chk_i (.*);

// File: tb/pcn_next_addr_tb_top.sv
module pcn_next_addr_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  jumpKind = 2'b00;
  logic [11:0] relOfs = '0;
  logic [15:0] zPtr = '0;
  logic        stall = 1'b0;
  logic [11:0] pc;
  logic [11:0] fetchAddr;
  logic        flush;

  int testCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  logic [11:0] mPc = '0;
  logic [11:0] mFetch = '0;
  logic        mFlush = 1'b1;

  always #10 clk = ~clk;

  pcn_next_addr dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .jumpKind  (jumpKind),
    .relOfs    (relOfs),
    .zPtr      (zPtr),
    .stall     (stall),
    .pc        (pc),
    .fetchAddr (fetchAddr),
    .flush     (flush)
  );

  task automatic compareAll(input string tag);
    testCnt++;
    if (pc !== mPc || fetchAddr !== mFetch || flush !== mFlush) begin
      failCnt++;
      $display("FAIL %s: pc=%0h fetch=%0h flush=%0b expected pc=%0h fetch=%0h flush=%0b",
               tag, pc, fetchAddr, flush, mPc, mFetch, mFlush);
    end
    testCnt++;
    if (fetchAddr !== (flush ? pc : pc + 12'd1)) begin
      failCnt++;
      $display("FAIL R9: fetch=%0h expected %0h (pc=%0h flush=%0b)",
               fetchAddr, flush ? pc : pc + 12'd1, pc, flush);
    end
  endtask

  task automatic doStep(input logic [1:0] k, input logic [11:0] o,
                        input logic [15:0] z, input logic s, input string tag);
    jumpKind = k;
    relOfs   = o;
    zPtr     = z;
    stall    = s;
    if (!s) begin
      if (mFlush) begin
        mFetch = mPc + 12'd1;
        mFlush = 1'b0;
      end else begin
        case (k)
          2'b00: begin mPc = mPc + 12'd1; mFetch = mPc + 12'd1; end
          2'b01: begin mPc = mPc + o + 12'd1; mFetch = mPc; mFlush = 1'b1; end
          2'b10: begin mPc = z[11:0]; mFetch = mPc; mFlush = 1'b1; end
          default: begin mPc = mPc + 12'd2; mFetch = mPc + 12'd1; end
        endcase
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;

    // first bubble after reset; a jump request must be ignored (R8, R2)
    doStep(2'b01, 12'd100, 16'h0000, 1'b0, "R8");
    doStep(2'b10, 12'd0, 16'h0777, 1'b0, "R3");

    for (int i = 0; i < 20; i++) doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");
    for (int i = 0; i < 10; i++) begin
      doStep(2'b11, 12'd0, 16'h0, 1'b0, "R6");
      doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");
    end

    // every relative offset, each followed by its bubble
    for (int i = 0; i < 4096; i++) begin
      doStep(2'b01, 12'(i), 16'h0, 1'b0, "R4");
      doStep(2'b00, 12'd0, 16'h0, 1'b0, "R2");
      doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");
    end

    // every indirect target with noisy upper bits; jump requests in the bubble
    for (int i = 0; i < 4096; i++) begin
      doStep(2'b10, 12'd0, {4'(i * 7 + 3), 12'(i)}, 1'b0, "R5");
      doStep(2'(i % 4), 12'(i * 13), 16'(i * 5), 1'b0, "R8");
      doStep(2'b11, 12'd0, 16'h0, 1'b0, "R6");
    end

    // wrap at the top of program memory
    doStep(2'b10, 12'd0, 16'hAFFE, 1'b0, "R5");
    doStep(2'b00, 12'd0, 16'h0, 1'b0, "R2");
    doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");
    doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");
    doStep(2'b10, 12'd0, 16'h0FFF, 1'b0, "R5");
    doStep(2'b00, 12'd0, 16'h0, 1'b0, "R2");
    doStep(2'b11, 12'd0, 16'h0, 1'b0, "R6");
    doStep(2'b01, 12'hFFE, 16'h0, 1'b0, "R4");

    // stalls with every kind, in and out of a bubble
    for (int i = 0; i < 64; i++) begin
      doStep(2'(i % 4), 12'(i * 9), 16'(i * 31), 1'b1, "R7");
      doStep(2'(i % 4), 12'(i * 9), 16'(i * 31), 1'b0, "R7");
    end
    doStep(2'b10, 12'd0, 16'h0123, 1'b0, "R5");
    doStep(2'b01, 12'd5, 16'h0, 1'b1, "R7");
    doStep(2'b10, 12'd0, 16'h0456, 1'b1, "R7");
    doStep(2'b10, 12'd0, 16'h0456, 1'b0, "R2");
    doStep(2'b00, 12'd0, 16'h0, 1'b0, "R3");

    finishRun();
  end

endmodule